// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block sits beside the stage registers of a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory access, write-back). Because operands are read in the second stage and results are written in the fifth, a later instruction can only be hurt by reading a register before an earlier one writes it. The unit watches the register numbers and write flags of the instructions in flight. For each execute-stage operand it chooses between the register-file value and a result bypassed from the memory or write-back stage.

The bypass selects are computed while the consumer is still in decode and registered as it enters execute. This keeps the compare logic out of the execute-stage mux path. When the producer in execute is a load and the instruction in decode needs its result, bypassing cannot deliver the value in time. The unit then holds the program counter and the fetch/decode register for one cycle and loads a bubble into decode/execute. A taken branch, resolved in execute, squashes the two wrong-path instructions behind it. The register file writes in the first half of a cycle and reads in the second, so a producer three instructions ahead needs no bypass.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While rst_ni is low both bypass selects read 00. With all inputs zero, hold, bubble and flush are low.
- R2: Select encoding: 00 takes the register file, 01 takes the write-back stage result, 10 takes the memory stage result. 11 never appears. A select applies to the instruction in execute and is set at the clock edge where that instruction leaves decode.
- R3: If the instruction in execute writes the register a decode operand reads, that operand's next select is 10.
- R4: If only the instruction in the memory stage writes that register, the next select is 01.
- R5: If both the execute and memory stage instructions write the same register a decode operand reads, the memory stage result wins and the select is 10.
- R6: Register 0 never matches as a destination, and a stage whose write flag is low never matches. Either case gives select 00 and no stall.
- R7: A load in execute that writes a register read by the decode instruction raises hold and bubble in the same cycle. On the following cycle, with the load now in the memory stage, hold is low and that operand's next select is 01.
- R8: A load whose destination is not read by the decode instruction, or is register 0, causes no hold and no bubble.
- R9: A producer that is three instructions ahead, and so no longer in execute or memory, leaves the select at 00.
- R10: A taken branch raises flush and bubble, with hold low.
- R11: In any cycle with bubble high, both selects are 00 in the next cycle.
- R12: The two operands are resolved independently and can bypass from different stages in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_rs1_i | input | REG_AW | First source register of the decode instruction |
| id_rs2_i | input | REG_AW | Second source register of the decode instruction |
| ex_rd_i | input | REG_AW | Destination register of the execute instruction |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | REG_AW | Destination register of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| branch_taken_i | input | 1 | Branch in execute is taken |
| fwd_a_o | output | 2 | Bypass select for the first execute operand |
| fwd_b_o | output | 2 | Bypass select for the second execute operand |
| hold_o | output | 1 | Hold program counter and fetch/decode register |
| bubble_o | output | 1 | Load a bubble into the decode/execute register |
| flush_o | output | 1 | Clear the fetch/decode register |

## Verification
Two bypass decisions can fall in the same cycle. One case has both later stages writing the register a single operand reads. The other has each operand taking its value from a different stage. The bench provokes the first by giving the execute and memory stages the same destination as both sources, and expects 10 on both selects. It provokes the second by matching one source to the execute destination and the other to the memory-stage destination, and expects 10 and 01. It also places a load-use stall directly before its release cycle to check that the select moves from 00 to write-back in consecutive cycles.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/pipe_fwd_pick.sv
module pipe_fwd_pick
  import pipe_hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              kill_i,
  output fwd_sel_e          sel_o
);
  logic ex_hit, mem_hit;

  // producer in EX reaches MEM when consumer reaches EX
  assign ex_hit  = ex_we_i  && (ex_rd_i  != '0) && (ex_rd_i  == src_i);
  assign mem_hit = mem_we_i && (mem_rd_i != '0) && (mem_rd_i == src_i);

  always_comb begin
    if (kill_i)       sel_o = SEL_RF;
    else if (ex_hit)  sel_o = SEL_MEM;
    else if (mem_hit) sel_o = SEL_WB;
    else              sel_o = SEL_RF;
  end
endmodule

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs1_i,
  input  logic [REG_AW-1:0] rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_load_i,
  input  logic              branch_i,
  output logic              hold_o,
  output logic              bubble_o,
  output logic              flush_o
);
  logic load_use;

  assign load_use = ex_load_i && ex_we_i && (ex_rd_i != '0) &&
                    ((ex_rd_i == rs1_i) || (ex_rd_i == rs2_i));

  // decode instruction is wrong-path on a taken branch: no hold needed
  assign hold_o   = load_use && !branch_i;
  assign flush_o  = branch_i;
  assign bubble_o = load_use || branch_i;
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import pipe_hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              branch_taken_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              hold_o,
  output logic              bubble_o,
  output logic              flush_o
);
  localparam int NumSrc = 2;

  logic [REG_AW-1:0] src[NumSrc];
  fwd_sel_e          sel_d[NumSrc];
  fwd_sel_e          sel_q[NumSrc];
  logic              bubble;

  assign src[0] = id_rs1_i;
  assign src[1] = id_rs2_i;

  pipe_stall_ctrl #(.REG_AW(REG_AW)) u_stall (
    .rs1_i     (id_rs1_i),
    .rs2_i     (id_rs2_i),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .branch_i  (branch_taken_i),
    .hold_o    (hold_o),
    .bubble_o  (bubble),
    .flush_o   (flush_o)
  );

  assign bubble_o = bubble;

  for (genvar g = 0; g < NumSrc; g++) begin : g_src
    pipe_fwd_pick #(.REG_AW(REG_AW)) u_pick (
      .src_i    (src[g]),
      .ex_rd_i  (ex_rd_i),
      .ex_we_i  (ex_we_i),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .kill_i   (bubble),
      .sel_o    (sel_d[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_q[g] <= SEL_RF;
      else         sel_q[g] <= sel_d[g];
    end
  end

  assign fwd_a_o = sel_q[0];
  assign fwd_b_o = sel_q[1];
endmodule

// File: rtl/pipe_hazard_chk.sv
module pipe_hazard_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] id_rs1_i,
  input logic [REG_AW-1:0] id_rs2_i,
  input logic [REG_AW-1:0] ex_rd_i,
  input logic              ex_we_i,
  input logic              ex_load_i,
  input logic [REG_AW-1:0] mem_rd_i,
  input logic              mem_we_i,
  input logic              branch_taken_i,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o,
  input logic              hold_o,
  input logic              bubble_o,
  input logic              flush_o
);
  // R2
  sel_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_a_o != 2'b11 && fwd_b_o != 2'b11);

  // R5
  mem_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bubble_o && ex_we_i && mem_we_i && ex_rd_i != '0 &&
     ex_rd_i == id_rs1_i && mem_rd_i == id_rs1_i) |=> fwd_a_o == 2'b10);

  // R6
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs1_i == '0 && id_rs2_i == '0) |=> fwd_a_o == 2'b00 && fwd_b_o == 2'b00);

  // R7
  load_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_load_i && ex_we_i && ex_rd_i != '0 && ex_rd_i == id_rs1_i &&
     !branch_taken_i) |-> hold_o && bubble_o);

  // R10
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> bubble_o && !hold_o);

  // R11
  bubble_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |=> fwd_a_o == 2'b00 && fwd_b_o == 2'b00);
endmodule

bind pipe_hazard_unit pipe_hazard_chk #(.REG_AW(REG_AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .id_rs1_i       (id_rs1_i),
  .id_rs2_i       (id_rs2_i),
  .ex_rd_i        (ex_rd_i),
  .ex_we_i        (ex_we_i),
  .ex_load_i      (ex_load_i),
  .mem_rd_i       (mem_rd_i),
  .mem_we_i       (mem_we_i),
  .branch_taken_i (branch_taken_i),
  .fwd_a_o        (fwd_a_o),
  .fwd_b_o        (fwd_b_o),
  .hold_o         (hold_o),
  .bubble_o       (bubble_o),
  .flush_o        (flush_o)
);

// File: tb/pipe_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module pipe_hazard_unit_tb_top;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rs1 = '0, rs2 = '0, ex_rd = '0, mem_rd = '0;
  logic          ex_we = 1'b0, ex_ld = 1'b0, mem_we = 1'b0, br = 1'b0;
  logic [1:0]    fwd_a, fwd_b;
  logic          hold, bubble, flush;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] q_a[$];
  logic [1:0] q_b[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  pipe_hazard_unit #(.REG_AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(rs1), .id_rs2_i(rs2),
    .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_ld),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .branch_taken_i(br),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .hold_o(hold), .bubble_o(bubble), .flush_o(flush)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: apply one decode-cycle view, check control, queue the selects due next cycle
  task automatic step(input string tag,
                      input logic [AW-1:0] s1, input logic [AW-1:0] s2,
                      input logic [AW-1:0] erd, input logic ewe, input logic eld,
                      input logic [AW-1:0] mrd, input logic mwe, input logic b,
                      input logic e_hold, input logic e_bub, input logic e_fl,
                      input logic [1:0] e_a, input logic [1:0] e_b);
    @(negedge clk);
    rs1 = s1; rs2 = s2; ex_rd = erd; ex_we = ewe; ex_ld = eld;
    mem_rd = mrd; mem_we = mwe; br = b;
    #1;
    check({tag, " ctl"}, {1'b0, hold, bubble, flush}, {1'b0, e_hold, e_bub, e_fl});
    q_a.push_back(e_a);
    q_b.push_back(e_b);
    q_tag.push_back(tag);
  endtask

  // monitor: selects registered at the preceding edge
  always @(negedge clk) begin
    if (rst_n && q_a.size() > 0) begin
      string t;
      logic [1:0] ea, eb;
      ea = q_a.pop_front();
      eb = q_b.pop_front();
      t  = q_tag.pop_front();
      check({t, " sel"}, {fwd_a, fwd_b}, {ea, eb});
    end
  end

  initial begin
    #(8ns * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {fwd_a, fwd_b}, 4'b0000);
    check("R1 ctl", {1'b0, hold, bubble, flush}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R3 R12: distance 1 ALU producer on rs1
    step("R3", 5'd3, 5'd4, 5'd3, 1, 0, 5'd0, 0, 0, 0, 0, 0, 2'b10, 2'b00);
    // R4: distance 2 on rs2
    step("R4", 5'd5, 5'd7, 5'd9, 1, 0, 5'd7, 1, 0, 0, 0, 0, 2'b00, 2'b01);
    // R5: both stages write the same source
    step("R5", 5'd6, 5'd6, 5'd6, 1, 0, 5'd6, 1, 0, 0, 0, 0, 2'b10, 2'b10);
    // R6: register 0 and write flag low
    step("R6 x0", 5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1, 0, 0, 0, 0, 2'b00, 2'b00);
    step("R6 we", 5'd8, 5'd8, 5'd8, 0, 0, 5'd8, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    // R7 R11: load-use on rs1, then release with the load in memory stage
    step("R7 stall", 5'd10, 5'd2, 5'd10, 1, 1, 5'd0, 0, 0, 1, 1, 0, 2'b00, 2'b00);
    step("R7 release", 5'd10, 5'd2, 5'd0, 0, 0, 5'd10, 1, 0, 0, 0, 0, 2'b01, 2'b00);
    // R7: load-use on rs2
    step("R7 rs2", 5'd1, 5'd13, 5'd13, 1, 1, 5'd0, 0, 0, 1, 1, 0, 2'b00, 2'b00);
    step("R7 rs2 release", 5'd1, 5'd13, 5'd0, 0, 0, 5'd13, 1, 0, 0, 0, 0, 2'b00, 2'b01);
    // R8: independent load, load to x0
    step("R8 indep", 5'd1, 5'd2, 5'd11, 1, 1, 5'd0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    step("R8 x0", 5'd0, 5'd4, 5'd0, 1, 1, 5'd0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    // R9: producer three ahead is past the memory stage
    step("R9", 5'd12, 5'd12, 5'd14, 1, 0, 5'd15, 1, 0, 0, 0, 0, 2'b00, 2'b00);
    // R10 R11: taken branch while a bypass would match
    step("R10", 5'd3, 5'd3, 5'd3, 1, 0, 5'd3, 1, 1, 0, 1, 1, 2'b00, 2'b00);
    // R12: operands from different stages in one cycle
    step("R12", 5'd20, 5'd21, 5'd20, 1, 0, 5'd21, 1, 0, 0, 0, 0, 2'b10, 2'b01);
    step("R12 swap", 5'd21, 5'd20, 5'd20, 1, 0, 5'd21, 1, 0, 0, 0, 0, 2'b01, 2'b10);
    step("idle", 5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule